// File: doc/BRIEF.md
# Keyed Decrementer Timer

This block is a 32-bit down counter that advances by one on each cycle in which a dedicated timer clock enable is high and the counting enable from the timer control logic is set. When the count passes through zero, wrapping from 0x00000000 to 0xFFFFFFFF, it latches an interrupt flag. The flag is forwarded as an interrupt request only while the interrupt enable is set. It stays latched until software clears it.

Software reads the live count at any time. The count is write-protected. Before a count write takes effect, software must first write a fixed unlock value to a separate key port. A count write made while the key is locked is dropped and sets a sticky error bit. Only the power-on reset input restores the counter and the interrupt flag. The system reset input relocks the key and clears the error bit, but the count and the flag keep their values across it.

Top module: `keyed_dec_timer`

## Requirements
- R1: While `por` is high at a clock edge, the count becomes 0xFFFFFFFF, the flag and the error bit become 0, and the key becomes locked.
- R2: On each edge where `tick` and `cnt_en` are both 1 and no count load happens, the count drops by exactly 1. If either input is 0, the count holds.
- R3: `cnt_rdata` always shows the current count register, including the value just loaded or decremented.
- R4: A key write of 32'h55CCAA33 unlocks the key. A key write of any other value locks it. The new key state applies from the next cycle.
- R5: A count write while the key is unlocked loads `cnt_wdata` at that edge. A load takes priority over a decrement in the same cycle.
- R6: A count write while the key is locked leaves the count unchanged and sets `wr_err`. `wr_err` stays at 1 until `por` or `sys_rst` is applied.
- R7: `flag` sets at the edge where a decrement takes the count from 0x00000000 to 0xFFFFFFFF, and it stays set until `flag_clr` is applied. A set and a clear in the same cycle leave the flag set.
- R8: `irq` is 1 exactly when `flag` is 1 and `irq_en` is 1. Clearing `irq_en` does not clear `flag`.
- R9: `sys_rst` relocks the key and clears `wr_err`. It leaves the count and `flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high; does not touch the count |
| tick | input | 1 | Timer clock enable |
| cnt_en | input | 1 | Counting enable from the timer control |
| irq_en | input | 1 | Interrupt enable (mask) |
| key_wr | input | 1 | Key register write strobe |
| key_data | input | 32 | Key write data |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write data |
| flag_clr | input | 1 | Clears the latched interrupt flag |
| cnt_rdata | output | 32 | Live count value |
| flag | output | 1 | Latched zero-crossing flag |
| irq | output | 1 | Enabled interrupt request |
| wr_err | output | 1 | Sticky locked-write error bit |

## Verification
A wrong decrement or a lost priority shows on `cnt_rdata` one edge after the cycle in question. An error in the key state cannot be read directly. It appears one cycle later, either as a count write that lands when it should not or as a `wr_err` bit that rises when it should not. A missed or spurious zero crossing shows on `flag` and `irq` at the same edge where `cnt_rdata` shows 0xFFFFFFFF. Reset separation is checked by applying `sys_rst` while the flag is set and the count is nonzero, then checking that both survive.

// File: rtl/kdc_pkg.sv
package kdc_pkg;

    localparam int unsigned CNT_W = 32;
    localparam logic [CNT_W-1:0] UNLOCK_KEY = 32'h55CC_AA33;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic load;
        cnt_t value;
    } cnt_load_t;

    typedef enum logic {
        KEY_LOCKED = 1'b0,
        KEY_OPEN   = 1'b1
    } key_state_e;

    // true when the top bit goes low to high between two count values
    function automatic logic msb_rise(cnt_t prev, cnt_t next);
        return !prev[CNT_W-1] && next[CNT_W-1];
    endfunction

endpackage

// File: rtl/kdc_key_guard.sv
module kdc_key_guard
    import kdc_pkg::*;
#(
    parameter bit SYSRST_RELOCK = 1'b1
) (
    input  logic clk,
    input  logic por,
    input  logic sys_rst,
    input  logic key_wr,
    input  cnt_t key_data,
    input  logic cnt_wr,
    output logic unlocked,
    output logic load_ok,
    output logic wr_err
);

    key_state_e state;
    logic       relock;

    generate
        if (SYSRST_RELOCK) begin : g_relock_both
            assign relock = por || sys_rst;
        end else begin : g_relock_por
            assign relock = por;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (relock)
            state <= KEY_LOCKED;
        else if (key_wr)
            state <= (key_data == UNLOCK_KEY) ? KEY_OPEN : KEY_LOCKED;
    end

    always_ff @(posedge clk) begin
        if (por || sys_rst)
            wr_err <= 1'b0;
        else if (cnt_wr && state == KEY_LOCKED)
            wr_err <= 1'b1;
    end

    assign unlocked = (state == KEY_OPEN);
    assign load_ok  = cnt_wr && unlocked;

endmodule

// File: rtl/kdc_counter.sv
module kdc_counter
    import kdc_pkg::*;
#(
    parameter cnt_t RESET_VAL = '1
) (
    input  logic      clk,
    input  logic      por,
    input  logic      tick,
    input  logic      run,
    input  cnt_load_t ld,
    output cnt_t      count,
    output logic      wrap
);

    cnt_t nxt;
    logic dec;

    always_comb begin
        dec = tick && run;
        nxt = count;
        if (ld.load)
            nxt = ld.value;
        else if (dec)
            nxt = count - cnt_t'(1);
    end

    assign wrap = !ld.load && dec && msb_rise(count, nxt);

    always_ff @(posedge clk) begin
        if (por)
            count <= RESET_VAL;
        else
            count <= nxt;
    end

endmodule

// File: rtl/kdc_irq_latch.sv
module kdc_irq_latch (
    input  logic clk,
    input  logic por,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (por)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assign irq = flag && en;

endmodule

// File: rtl/keyed_dec_timer.sv
module keyed_dec_timer
    import kdc_pkg::*;
#(
    parameter cnt_t RESET_VAL     = '1,
    parameter bit   SYSRST_RELOCK = 1'b1
) (
    input  logic             clk,
    input  logic             por,
    input  logic             sys_rst,
    input  logic             tick,
    input  logic             cnt_en,
    input  logic             irq_en,
    input  logic             key_wr,
    input  logic [CNT_W-1:0] key_data,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic             flag,
    output logic             irq,
    output logic             wr_err
);

    logic      unlocked;
    logic      load_ok;
    logic      wrap;
    cnt_load_t ld;
    cnt_t      count;

    kdc_key_guard #(
        .SYSRST_RELOCK(SYSRST_RELOCK)
    ) key_i (
        .clk     (clk),
        .por     (por),
        .sys_rst (sys_rst),
        .key_wr  (key_wr),
        .key_data(key_data),
        .cnt_wr  (cnt_wr),
        .unlocked(unlocked),
        .load_ok (load_ok),
        .wr_err  (wr_err)
    );

    assign ld.load  = load_ok;
    assign ld.value = cnt_wdata;

    kdc_counter #(
        .RESET_VAL(RESET_VAL)
    ) cnt_i (
        .clk  (clk),
        .por  (por),
        .tick (tick),
        .run  (cnt_en),
        .ld   (ld),
        .count(count),
        .wrap (wrap)
    );

    kdc_irq_latch irq_i (
        .clk (clk),
        .por (por),
        .set (wrap),
        .clr (flag_clr),
        .en  (irq_en),
        .flag(flag),
        .irq (irq)
    );

    assign cnt_rdata = count;

endmodule

// File: rtl/keyed_dec_timer_chk.sv
module keyed_dec_timer_chk
    import kdc_pkg::*;
(
    input logic       clk,
    input logic       por,
    input logic       tick,
    input logic       cnt_en,
    input logic       irq_en,
    input logic       key_wr,
    input logic [31:0] key_data,
    input logic       cnt_wr,
    input logic [31:0] cnt_rdata,
    input logic       flag,
    input logic       irq,
    input logic       wr_err,
    input logic       unlocked
);

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (por)
        (tick && cnt_en && !(cnt_wr && unlocked)) |=> (cnt_rdata == $past(cnt_rdata) - 32'd1));

    // R4
    bad_key_locks_chk: assert property (@(posedge clk) disable iff (por)
        (key_wr && key_data != UNLOCK_KEY) |=> !unlocked);

    // R6
    locked_write_err_chk: assert property (@(posedge clk) disable iff (por)
        (cnt_wr && !unlocked) |=> wr_err);

    // R6
    locked_write_ignored_chk: assert property (@(posedge clk) disable iff (por)
        (cnt_wr && !unlocked && !(tick && cnt_en)) |=> $stable(cnt_rdata));

    // R7
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (por)
        (tick && cnt_en && cnt_rdata == 32'd0 && !(cnt_wr && unlocked)) |=> flag);

    // R8
    masked_irq_chk: assert property (@(posedge clk) disable iff (por)
        !irq_en |-> !irq);

endmodule

bind keyed_dec_timer keyed_dec_timer_chk chk_i (
    .clk      (clk),
    .por      (por),
    .tick     (tick),
    .cnt_en   (cnt_en),
    .irq_en   (irq_en),
    .key_wr   (key_wr),
    .key_data (key_data),
    .cnt_wr   (cnt_wr),
    .cnt_rdata(cnt_rdata),
    .flag     (flag),
    .irq      (irq),
    .wr_err   (wr_err),
    .unlocked (unlocked)
);

// File: tb/keyed_dec_timer_tb.sv
module keyed_dec_timer_tb_top;

    localparam logic [31:0] KEY = 32'h55CC_AA33;

    logic        clk = 1'b0;
    logic        por, sys_rst, tick, cnt_en, irq_en, key_wr, cnt_wr, flag_clr;
    logic [31:0] key_data, cnt_wdata, cnt_rdata;
    logic        flag, irq, wr_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keyed_dec_timer dut_i (
        .clk(clk), .por(por), .sys_rst(sys_rst), .tick(tick), .cnt_en(cnt_en),
        .irq_en(irq_en), .key_wr(key_wr), .key_data(key_data), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .flag_clr(flag_clr), .cnt_rdata(cnt_rdata),
        .flag(flag), .irq(irq), .wr_err(wr_err)
    );

    typedef struct packed {
        logic        t;
        logic        e;
        logic        kw;
        logic [31:0] kd;
        logic        w;
        logic [31:0] wd;
        logic [31:0] exp_cnt;
        logic        exp_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 1'b0, 32'h0,        1'b0, 32'h0, 32'hFFFF_FFFE, 1'b0}, // R2 decrement
        '{1'b1, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0, 32'hFFFF_FFFE, 1'b0}, // R2 hold, no enable
        '{1'b0, 1'b1, 1'b0, 32'h0,        1'b0, 32'h0, 32'hFFFF_FFFE, 1'b0}, // R2 hold, no tick
        '{1'b0, 1'b0, 1'b0, 32'h0,        1'b1, 32'h5, 32'hFFFF_FFFE, 1'b1}, // R6 locked write
        '{1'b0, 1'b0, 1'b1, KEY,          1'b0, 32'h0, 32'hFFFF_FFFE, 1'b1}, // R4 unlock
        '{1'b1, 1'b1, 1'b0, 32'h0,        1'b1, 32'h2, 32'h0000_0002, 1'b1}, // R5 load beats tick
        '{1'b1, 1'b1, 1'b0, 32'h0,        1'b0, 32'h0, 32'h0000_0001, 1'b1}, // R2
        '{1'b0, 1'b0, 1'b1, 32'h1234_5678, 1'b0, 32'h0, 32'h0000_0001, 1'b1}, // R4 relock
        '{1'b0, 1'b0, 1'b0, 32'h0,        1'b1, 32'h7, 32'h0000_0001, 1'b1}, // R4 write blocked
        '{1'b1, 1'b1, 1'b0, 32'h0,        1'b0, 32'h0, 32'h0000_0000, 1'b1}  // R2 reach zero
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        sys_rst = 0; tick = 0; cnt_en = 0; key_wr = 0; key_data = '0;
        cnt_wr = 0; cnt_wdata = '0; flag_clr = 0; por = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        irq_en = 1;
        por = 1;
        cyc();
        por = 0;
        // R1 reset state
        chk("R1 count", cnt_rdata, 32'hFFFF_FFFF);
        chk("R1 flag", {31'b0, flag}, 32'd0);
        chk("R1 err", {31'b0, wr_err}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            idle();
            tick = TBL[i].t; cnt_en = TBL[i].e; key_wr = TBL[i].kw; key_data = TBL[i].kd;
            cnt_wr = TBL[i].w; cnt_wdata = TBL[i].wd;
            cyc();
            chk($sformatf("R3 live count row %0d", i), cnt_rdata, TBL[i].exp_cnt);
            chk($sformatf("R6 err row %0d", i), {31'b0, wr_err}, {31'b0, TBL[i].exp_err});
        end
        chk("R7 no flag before wrap", {31'b0, flag}, 32'd0);

        // R7 wrap through zero
        idle(); tick = 1; cnt_en = 1; cyc();
        chk("R7 wrap count", cnt_rdata, 32'hFFFF_FFFF);
        chk("R7 flag set", {31'b0, flag}, 32'd1);
        chk("R8 irq on", {31'b0, irq}, 32'd1);

        // R8 mask keeps flag
        idle(); irq_en = 0; cyc();
        chk("R8 irq masked", {31'b0, irq}, 32'd0);
        chk("R8 flag kept", {31'b0, flag}, 32'd1);

        // R7 sticky over further counting
        idle(); tick = 1; cnt_en = 1; cyc();
        chk("R7 sticky count", cnt_rdata, 32'hFFFF_FFFE);
        chk("R7 sticky flag", {31'b0, flag}, 32'd1);

        idle(); flag_clr = 1; cyc();
        chk("R7 cleared", {31'b0, flag}, 32'd0);

        // R7 set wins over clear
        idle(); key_wr = 1; key_data = KEY; cyc();
        idle(); cnt_wr = 1; cnt_wdata = 32'h0; cyc();
        chk("R5 load zero", cnt_rdata, 32'h0);
        idle(); tick = 1; cnt_en = 1; flag_clr = 1; cyc();
        chk("R7 set over clear", {31'b0, flag}, 32'd1);
        chk("R7 wrap again", cnt_rdata, 32'hFFFF_FFFF);

        // R9 system reset keeps count and flag, relocks, clears err
        idle(); sys_rst = 1; cyc();
        chk("R9 count kept", cnt_rdata, 32'hFFFF_FFFF);
        chk("R9 flag kept", {31'b0, flag}, 32'd1);
        chk("R9 err cleared", {31'b0, wr_err}, 32'd0);
        idle(); cnt_wr = 1; cnt_wdata = 32'h9; cyc();
        chk("R9 relocked count", cnt_rdata, 32'hFFFF_FFFF);
        chk("R9 relocked err", {31'b0, wr_err}, 32'd1);

        // R1 power-on reset again
        idle(); por = 1; cyc(); idle();
        chk("R1 por count", cnt_rdata, 32'hFFFF_FFFF);
        chk("R1 por flag", {31'b0, flag}, 32'd0);
        chk("R1 por err", {31'b0, wr_err}, 32'd0);
        idle(); cnt_wr = 1; cnt_wdata = 32'h3; cyc();
        chk("R1 locked after por", cnt_rdata, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule